// File: doc/BRIEF.md
# Clock Source Transition Sequencer

This block sequences a system between three clock sources: a low-frequency sub oscillator, the main oscillator, and a PLL that multiplies the main oscillator. It also manages two stopped states: one with the PLL and main oscillator halted, and one with the sub oscillator halted. Whenever a target clock needs its oscillator or PLL to settle first, the block enables that source and keeps the system on the old clock, or halted in the case of a wake-up. It counts a stabilization interval of oscillator ticks and only then switches the clock selector and updates its status.

All clocks are modelled as enable outputs and tick inputs inside one synchronous domain. `osc_tick` marks one oscillation-clock period and `sub_tick` marks one sub-clock period. Software-style polling is supported through two status bits that change only when a transition has fully finished. While a transition is running, any further mode, stop or wake request is dropped.

Top module: `clk_mode_ctrl`

## Requirements
- R1: After reset the block is in main mode: `clk_sel`=00 (main), `main_osc_en`=1, `pll_en`=0, `sub_osc_en`=1, `stat_main`=1, `stat_sub`=0, `busy`=0, `sel_err`=0.
- R2: From main mode, a request with `req_mode`=10 (PLL) sets `pll_en` and `busy`, keeps `clk_sel`=00 and the status bits unchanged for exactly 2^FIX_SH `osc_tick` pulses, then selects `clk_sel`=10 with `stat_main`=0 and `stat_sub`=0.
- R3: Switches that need no settling take effect one clock after the request. From PLL to main (`req_mode`=00), `pll_en` goes to 0. From main or PLL to sub (`req_mode`=01), the result is `clk_sel`=01, `main_osc_en`=0, `pll_en`=0 and `stat_sub`=1.
- R4: From sub mode, a PLL request with `wait_sel` of 10 or 11 enables both the main oscillator and the PLL while `clk_sel` stays 01. It then waits 2^SEL_SH2 or 2^SEL_SH3 `osc_tick` pulses respectively before selecting the PLL.
- R5: A PLL request from sub mode, or a wake from PLL stop, with `wait_sel` of 00 or 01 is refused. The mode, enables and status stay as they were, `busy` stays 0, and `sel_err` is 1 for exactly one cycle.
- R6: In PLL mode, `stop_req` enters PLL stop: `clk_sel`=11 (halted), main oscillator and PLL disabled, sub oscillator enabled, status bits held. A `wake_req` with a valid `wait_sel` enables main oscillator and PLL. It holds `clk_sel`=11 for the selected interval of `osc_tick` pulses and then selects the PLL.
- R7: In sub mode, `stop_req` disables all three oscillators with `clk_sel`=11. A `wake_req` re-enables only the sub oscillator, waits 2^FIX_SH `sub_tick` pulses (`osc_tick` not counted), and returns to sub mode with `clk_sel`=01.
- R8: From sub mode, a request with `req_mode`=00 enables the main oscillator, holds `clk_sel`=01 for 2^SEL_SHn `osc_tick` pulses where n is `wait_sel` (any value), and then selects main with `stat_main`=1.
- R9: While `busy` is 1, mode, stop and wake requests are ignored. They neither restart nor shorten the interval, and the final mode is the one originally requested.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Mode request strobe |
| req_mode | input | 2 | Target mode: 00 main, 01 sub, 10 PLL, 11 ignored |
| wait_sel | input | 2 | Stabilization interval select for shared waits |
| stop_req | input | 1 | Enter the stop state of the current mode (PLL or sub) |
| wake_req | input | 1 | Leave the current stop state |
| osc_tick | input | 1 | One oscillation-clock period elapsed |
| sub_tick | input | 1 | One sub-clock period elapsed |
| clk_sel | output | 2 | Active clock: 00 main, 01 sub, 10 PLL, 11 halted |
| main_osc_en | output | 1 | Main oscillator enable |
| pll_en | output | 1 | PLL enable |
| sub_osc_en | output | 1 | Sub oscillator enable |
| stat_main | output | 1 | Main-oscillator mode in effect |
| stat_sub | output | 1 | Sub-clock mode in effect |
| busy | output | 1 | Transition in progress |
| sel_err | output | 1 | One-cycle pulse on a refused request |

## Verification
The bench builds the block with FIX_SH=5 and select shifts 2, 3, 6 and 7, so every interval is between 4 and 128 ticks. The ordering of the defaults is kept: the two refused selects are shorter than the fixed wait and the two accepted ones are longer. Every wait therefore runs to completion, and each tick pulse can be counted exactly. The gated tick patterns (every second oscillator tick, every third sub tick) show that intervals are measured in ticks rather than cycles.

// File: rtl/clk_mode_pkg.sv
package clk_mode_pkg;

   typedef enum logic [3:0] {
      ST_MAIN,
      ST_PLL,
      ST_SUB,
      ST_PSTOP,
      ST_SSTOP,
      ST_W_M2P,
      ST_W_S2P,
      ST_W_PWAKE,
      ST_W_SWAKE,
      ST_W_S2M
   } cm_state_e;

   localparam logic [1:0] CSEL_MAIN = 2'b00;
   localparam logic [1:0] CSEL_SUB  = 2'b01;
   localparam logic [1:0] CSEL_PLL  = 2'b10;
   localparam logic [1:0] CSEL_HALT = 2'b11;

   localparam logic [1:0] REQ_MAIN = 2'b00;
   localparam logic [1:0] REQ_SUB  = 2'b01;
   localparam logic [1:0] REQ_PLL  = 2'b10;

   function automatic logic is_wait(input cm_state_e s);
      return (s == ST_W_M2P) || (s == ST_W_S2P) || (s == ST_W_PWAKE) ||
             (s == ST_W_SWAKE) || (s == ST_W_S2M);
   endfunction

endpackage

// File: rtl/clk_mode_timer.sv
module clk_mode_timer #(
   parameter int FIX_SH  = 14,
   parameter int SEL_SH0 = 10,
   parameter int SEL_SH1 = 13,
   parameter int SEL_SH2 = 15,
   parameter int SEL_SH3 = 17
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       use_fixed,
   input  logic       on_sub,
   input  logic [1:0] sel,
   input  logic       active,
   input  logic       osc_tick,
   input  logic       sub_tick,
   output logic       done
);

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   localparam int MAX_SH = max_of(max_of(FIX_SH, SEL_SH0),
                                  max_of(max_of(SEL_SH1, SEL_SH2), SEL_SH3));
   localparam int CW = (MAX_SH < 1) ? 1 : MAX_SH;
   localparam int SH_TBL [4] = '{SEL_SH0, SEL_SH1, SEL_SH2, SEL_SH3};
   localparam logic [CW-1:0] FIX_TERM = CW'((64'd1 << FIX_SH) - 64'd1);

   if (FIX_SH < 1 || MAX_SH > 40) begin : g_bad_range
      $error("clk_mode_timer: shift parameters out of range");
   end
   if (SEL_SH2 < FIX_SH || SEL_SH3 < FIX_SH) begin : g_bad_order
      $error("clk_mode_timer: accepted selects must not be shorter than the fixed wait");
   end

   logic [CW-1:0] term_tbl [4];
   for (genvar g = 0; g < 4; g++) begin : g_term
      assign term_tbl[g] = CW'((64'd1 << SH_TBL[g]) - 64'd1);
   end

   logic [CW-1:0] cnt;
   logic          fix_q;
   logic          sub_q;
   logic [1:0]    sel_q;
   logic [CW-1:0] term_m1;
   logic          tick;

   assign term_m1 = fix_q ? FIX_TERM : term_tbl[sel_q];
   assign tick    = sub_q ? sub_tick : osc_tick;
   assign done    = active && tick && (cnt == term_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         fix_q <= 1'b0;
         sub_q <= 1'b0;
         sel_q <= 2'b00;
      end else if (start) begin
         cnt   <= '0;
         fix_q <= use_fixed;
         sub_q <= on_sub;
         sel_q <= sel;
      end else if (active && tick) begin
         cnt <= cnt + 1'b1;
      end
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (cnt <= term_m1)); // R2

endmodule

// File: rtl/clk_mode_fsm.sv
module clk_mode_fsm
   import clk_mode_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic [1:0] req_mode,
   input  logic [1:0] wait_sel,
   input  logic       stop_req,
   input  logic       wake_req,
   input  logic       wait_done,
   output cm_state_e  state,
   output logic       wait_start,
   output logic       wait_fixed,
   output logic       wait_on_sub,
   output logic       sel_err,
   output logic       stat_main,
   output logic       stat_sub
);

   cm_state_e nxt;
   logic      refuse;
   logic      want_pll;
   logic      want_main;
   logic      want_sub;

   assign want_pll  = req_valid && (req_mode == REQ_PLL);
   assign want_main = req_valid && (req_mode == REQ_MAIN);
   assign want_sub  = req_valid && (req_mode == REQ_SUB);

   always_comb begin
      nxt         = state;
      wait_start  = 1'b0;
      wait_fixed  = 1'b0;
      wait_on_sub = 1'b0;
      refuse      = 1'b0;
      unique case (state)
         ST_MAIN: begin
            if (want_pll) begin
               nxt        = ST_W_M2P;
               wait_start = 1'b1;
               wait_fixed = 1'b1;
            end else if (want_sub) begin
               nxt = ST_SUB;
            end
         end
         ST_PLL: begin
            if (stop_req)       nxt = ST_PSTOP;
            else if (want_main) nxt = ST_MAIN;
            else if (want_sub)  nxt = ST_SUB;
         end
         ST_SUB: begin
            if (stop_req) begin
               nxt = ST_SSTOP;
            end else if (want_pll) begin
               if (wait_sel[1]) begin
                  nxt        = ST_W_S2P;
                  wait_start = 1'b1;
               end else begin
                  refuse = 1'b1;
               end
            end else if (want_main) begin
               nxt        = ST_W_S2M;
               wait_start = 1'b1;
            end
         end
         ST_PSTOP: begin
            if (wake_req) begin
               if (wait_sel[1]) begin
                  nxt        = ST_W_PWAKE;
                  wait_start = 1'b1;
               end else begin
                  refuse = 1'b1;
               end
            end
         end
         ST_SSTOP: begin
            if (wake_req) begin
               nxt         = ST_W_SWAKE;
               wait_start  = 1'b1;
               wait_fixed  = 1'b1;
               wait_on_sub = 1'b1;
            end
         end
         ST_W_M2P, ST_W_S2P, ST_W_PWAKE: if (wait_done) nxt = ST_PLL;
         ST_W_SWAKE:                     if (wait_done) nxt = ST_SUB;
         ST_W_S2M:                       if (wait_done) nxt = ST_MAIN;
         default: nxt = ST_MAIN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_MAIN;
         sel_err   <= 1'b0;
         stat_main <= 1'b1;
         stat_sub  <= 1'b0;
      end else begin
         state   <= nxt;
         sel_err <= refuse;
         if (nxt == ST_MAIN) begin
            stat_main <= 1'b1;
            stat_sub  <= 1'b0;
         end else if (nxt == ST_PLL) begin
            stat_main <= 1'b0;
            stat_sub  <= 1'b0;
         end else if (nxt == ST_SUB) begin
            stat_main <= 1'b0;
            stat_sub  <= 1'b1;
         end
      end
   end

   AST_PLL_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PLL && $past(state) != ST_PLL) |-> $past(wait_done)); // R2
   AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (is_wait(state) && !wait_done) |=> $stable(state)); // R9
   AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (is_wait(state) && !wait_done) |=> $stable({stat_main, stat_sub})); // R9
   AST_BAD_SEL_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SUB && want_pll && !stop_req && !wait_sel[1])
      |=> (state == ST_SUB && sel_err)); // R5

endmodule

// File: rtl/clk_mode_outmap.sv
module clk_mode_outmap
   import clk_mode_pkg::*;
(
   input  cm_state_e  state,
   output logic [1:0] clk_sel,
   output logic       main_osc_en,
   output logic       pll_en,
   output logic       sub_osc_en,
   output logic       busy
);

   always_comb begin
      clk_sel     = CSEL_MAIN;
      main_osc_en = 1'b1;
      pll_en      = 1'b0;
      sub_osc_en  = 1'b1;
      unique case (state)
         ST_MAIN:    begin clk_sel = CSEL_MAIN; main_osc_en = 1'b1; pll_en = 1'b0; sub_osc_en = 1'b1; end
         ST_PLL:     begin clk_sel = CSEL_PLL;  main_osc_en = 1'b1; pll_en = 1'b1; sub_osc_en = 1'b1; end
         ST_SUB:     begin clk_sel = CSEL_SUB;  main_osc_en = 1'b0; pll_en = 1'b0; sub_osc_en = 1'b1; end
         ST_PSTOP:   begin clk_sel = CSEL_HALT; main_osc_en = 1'b0; pll_en = 1'b0; sub_osc_en = 1'b1; end
         ST_SSTOP:   begin clk_sel = CSEL_HALT; main_osc_en = 1'b0; pll_en = 1'b0; sub_osc_en = 1'b0; end
         ST_W_M2P:   begin clk_sel = CSEL_MAIN; main_osc_en = 1'b1; pll_en = 1'b1; sub_osc_en = 1'b1; end
         ST_W_S2P:   begin clk_sel = CSEL_SUB;  main_osc_en = 1'b1; pll_en = 1'b1; sub_osc_en = 1'b1; end
         ST_W_PWAKE: begin clk_sel = CSEL_HALT; main_osc_en = 1'b1; pll_en = 1'b1; sub_osc_en = 1'b1; end
         ST_W_SWAKE: begin clk_sel = CSEL_HALT; main_osc_en = 1'b0; pll_en = 1'b0; sub_osc_en = 1'b1; end
         ST_W_S2M:   begin clk_sel = CSEL_SUB;  main_osc_en = 1'b1; pll_en = 1'b0; sub_osc_en = 1'b1; end
         default:    begin clk_sel = CSEL_MAIN; end
      endcase
   end

   assign busy = is_wait(state);

endmodule

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl
   import clk_mode_pkg::*;
#(
   parameter int FIX_SH  = 14,
   parameter int SEL_SH0 = 10,
   parameter int SEL_SH1 = 13,
   parameter int SEL_SH2 = 15,
   parameter int SEL_SH3 = 17
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic [1:0] req_mode,
   input  logic [1:0] wait_sel,
   input  logic       stop_req,
   input  logic       wake_req,
   input  logic       osc_tick,
   input  logic       sub_tick,
   output logic [1:0] clk_sel,
   output logic       main_osc_en,
   output logic       pll_en,
   output logic       sub_osc_en,
   output logic       stat_main,
   output logic       stat_sub,
   output logic       busy,
   output logic       sel_err
);

   cm_state_e state;
   logic      wait_start;
   logic      wait_fixed;
   logic      wait_on_sub;
   logic      wait_done;

   clk_mode_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_mode    (req_mode),
      .wait_sel    (wait_sel),
      .stop_req    (stop_req),
      .wake_req    (wake_req),
      .wait_done   (wait_done),
      .state       (state),
      .wait_start  (wait_start),
      .wait_fixed  (wait_fixed),
      .wait_on_sub (wait_on_sub),
      .sel_err     (sel_err),
      .stat_main   (stat_main),
      .stat_sub    (stat_sub)
   );

   clk_mode_timer #(
      .FIX_SH  (FIX_SH),
      .SEL_SH0 (SEL_SH0),
      .SEL_SH1 (SEL_SH1),
      .SEL_SH2 (SEL_SH2),
      .SEL_SH3 (SEL_SH3)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (wait_start),
      .use_fixed (wait_fixed),
      .on_sub    (wait_on_sub),
      .sel       (wait_sel),
      .active    (busy),
      .osc_tick  (osc_tick),
      .sub_tick  (sub_tick),
      .done      (wait_done)
   );

   clk_mode_outmap u_outmap (
      .state       (state),
      .clk_sel     (clk_sel),
      .main_osc_en (main_osc_en),
      .pll_en      (pll_en),
      .sub_osc_en  (sub_osc_en),
      .busy        (busy)
   );

endmodule

// File: tb/clk_mode_ctrl_bench.sv
module clk_mode_ctrl_bench;

   localparam int FIX = 5;
   localparam int SH0 = 2;
   localparam int SH1 = 3;
   localparam int SH2 = 6;
   localparam int SH3 = 7;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [1:0] req_mode = 2'b00;
   logic [1:0] wait_sel = 2'b00;
   logic       stop_req = 1'b0;
   logic       wake_req = 1'b0;
   logic       osc_tick = 1'b0;
   logic       sub_tick = 1'b0;
   logic [1:0] clk_sel;
   logic       main_osc_en, pll_en, sub_osc_en, stat_main, stat_sub, busy, sel_err;

   int n_chk = 0;
   int n_err = 0;

   always #2.5ns clk = ~clk;

   clk_mode_ctrl #(
      .FIX_SH(FIX), .SEL_SH0(SH0), .SEL_SH1(SH1), .SEL_SH2(SH2), .SEL_SH3(SH3)
   ) u_clk_mode_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
      .wait_sel(wait_sel), .stop_req(stop_req), .wake_req(wake_req),
      .osc_tick(osc_tick), .sub_tick(sub_tick), .clk_sel(clk_sel),
      .main_osc_en(main_osc_en), .pll_en(pll_en), .sub_osc_en(sub_osc_en),
      .stat_main(stat_main), .stat_sub(stat_sub), .busy(busy), .sel_err(sel_err)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // packs {clk_sel, main, pll, sub, stat_main, stat_sub, busy}
   function automatic int outs();
      return {clk_sel, main_osc_en, pll_en, sub_osc_en, stat_main, stat_sub, busy};
   endfunction

   function automatic int pack(input int cs, input int m, input int p, input int s,
                               input int sm, input int ss, input int b);
      return (cs << 6) | (m << 5) | (p << 4) | (s << 3) | (sm << 2) | (ss << 1) | b;
   endfunction

   task automatic idle_inputs();
      req_valid = 1'b0; stop_req = 1'b0; wake_req = 1'b0;
      osc_tick = 1'b0; sub_tick = 1'b0;
   endtask

   task automatic do_req(input logic [1:0] mode, input logic [1:0] sel);
      @(negedge clk);
      req_valid = 1'b1; req_mode = mode; wait_sel = sel;
   endtask

   task automatic do_stop();
      @(negedge clk);
      stop_req = 1'b1;
   endtask

   task automatic do_wake(input logic [1:0] sel);
      @(negedge clk);
      wake_req = 1'b1; wait_sel = sel;
   endtask

   // Drives ticks while busy; counts ticks consumed and clk_sel mismatches.
   task automatic run_wait(input bit on_sub, input int period, input logic [1:0] hold_sel,
                           input int inject, output int ticks, output int bad_sel);
      ticks = 0; bad_sel = 0;
      for (int k = 0; k < 5000; k++) begin
         @(negedge clk);
         idle_inputs();
         if (!busy) break;
         if (clk_sel != hold_sel) bad_sel++;
         if (k == inject) begin
            req_valid = 1'b1; req_mode = 2'b01; stop_req = 1'b1; wake_req = 1'b1;
         end
         if (k % period == 0) begin
            ticks++;
            if (on_sub) sub_tick = 1'b1; else osc_tick = 1'b1;
         end
      end
   endtask

   task automatic t_reset();
      chk("R1 reset outputs", outs(), pack(0, 1, 0, 1, 1, 0, 0));
      chk("R1 reset sel_err", sel_err, 0);
   endtask

   task automatic t_main_to_pll();
      int tk, bad;
      do_req(2'b10, 2'b00);
      @(negedge clk); idle_inputs();
      chk("R2 wait start outputs", outs(), pack(0, 1, 1, 1, 1, 0, 1));
      run_wait(1'b0, 1, 2'b00, 5, tk, bad);
      chk("R2/R9 tick count main->pll", tk, 1 << FIX);
      chk("R2 clock held on main", bad, 0);
      chk("R2/R9 final pll mode", outs(), pack(2, 1, 1, 1, 0, 0, 0));
   endtask

   task automatic t_pll_stop_wake();
      int tk, bad;
      do_stop();
      @(negedge clk); idle_inputs();
      chk("R6 pll stop outputs", outs(), pack(3, 0, 0, 1, 0, 0, 0));
      do_wake(2'b01);
      @(negedge clk); idle_inputs();
      chk("R5 wake refused sel_err", sel_err, 1);
      chk("R5 wake refused outputs", outs(), pack(3, 0, 0, 1, 0, 0, 0));
      @(negedge clk);
      chk("R5 sel_err one cycle", sel_err, 0);
      do_wake(2'b10);
      @(negedge clk); idle_inputs();
      chk("R6 wake wait outputs", outs(), pack(3, 1, 1, 1, 0, 0, 1));
      run_wait(1'b0, 2, 2'b11, -1, tk, bad);
      chk("R6 tick count pll wake", tk, 1 << SH2);
      chk("R6 clock held halted", bad, 0);
      chk("R6 final pll mode", outs(), pack(2, 1, 1, 1, 0, 0, 0));
   endtask

   task automatic t_pll_to_sub();
      do_req(2'b01, 2'b00);
      @(negedge clk); idle_inputs();
      chk("R3 pll->sub immediate", outs(), pack(1, 0, 0, 1, 0, 1, 0));
   endtask

   task automatic t_sub_bad_sel();
      do_req(2'b10, 2'b00);
      @(negedge clk); idle_inputs();
      chk("R5 sub->pll refused sel_err", sel_err, 1);
      chk("R5 sub->pll refused outputs", outs(), pack(1, 0, 0, 1, 0, 1, 0));
      @(negedge clk);
      chk("R5 sel_err cleared", sel_err, 0);
      chk("R5 still sub", outs(), pack(1, 0, 0, 1, 0, 1, 0));
   endtask

   task automatic t_sub_to_pll();
      int tk, bad;
      do_req(2'b10, 2'b11);
      @(negedge clk); idle_inputs();
      chk("R4 shared wait outputs", outs(), pack(1, 1, 1, 1, 0, 1, 1));
      run_wait(1'b0, 1, 2'b01, -1, tk, bad);
      chk("R4 tick count sub->pll", tk, 1 << SH3);
      chk("R4 clock held on sub", bad, 0);
      chk("R4 final pll mode", outs(), pack(2, 1, 1, 1, 0, 0, 0));
   endtask

   task automatic t_pll_to_main();
      do_req(2'b00, 2'b00);
      @(negedge clk); idle_inputs();
      chk("R3 pll->main immediate", outs(), pack(0, 1, 0, 1, 1, 0, 0));
   endtask

   task automatic t_main_to_sub();
      do_req(2'b01, 2'b00);
      @(negedge clk); idle_inputs();
      chk("R3 main->sub immediate", outs(), pack(1, 0, 0, 1, 0, 1, 0));
   endtask

   task automatic t_sub_stop_wake();
      int tk, bad;
      do_stop();
      @(negedge clk); idle_inputs();
      chk("R7 sub stop outputs", outs(), pack(3, 0, 0, 0, 0, 1, 0));
      do_wake(2'b00);
      @(negedge clk); idle_inputs();
      chk("R7 sub wake outputs", outs(), pack(3, 0, 0, 1, 0, 1, 1));
      // osc ticks alone must not advance the sub wake
      for (int k = 0; k < 40; k++) begin
         @(negedge clk); osc_tick = 1'b1;
      end
      @(negedge clk); osc_tick = 1'b0;
      chk("R7 osc ticks not counted", busy, 1);
      run_wait(1'b1, 3, 2'b11, -1, tk, bad);
      chk("R7 sub tick count", tk, 1 << FIX);
      chk("R7 clock held halted", bad, 0);
      chk("R7 final sub mode", outs(), pack(1, 0, 0, 1, 0, 1, 0));
   endtask

   task automatic t_sub_to_main();
      int tk, bad;
      do_req(2'b00, 2'b00);
      @(negedge clk); idle_inputs();
      chk("R8 main start outputs", outs(), pack(1, 1, 0, 1, 0, 1, 1));
      run_wait(1'b0, 1, 2'b01, -1, tk, bad);
      chk("R8 tick count sub->main", tk, 1 << SH0);
      chk("R8 clock held on sub", bad, 0);
      chk("R8 final main mode", outs(), pack(0, 1, 0, 1, 1, 0, 0));
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            t_reset();
            rst_n = 1'b1;
            @(negedge clk);
            t_reset();
            t_main_to_pll();
            t_pll_stop_wake();
            t_pll_to_sub();
            t_sub_bad_sel();
            t_sub_to_pll();
            t_pll_to_main();
            t_main_to_sub();
            t_sub_stop_wake();
            t_sub_to_main();
         end
         begin
            repeat (100000) @(posedge clk);
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
         end
      join_any
      disable fork;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule